// File: doc/BRIEF.md
# Per-Channel ADC Power Sequencer

This block steps each channel of a multichannel audio ADC through power-down, a wait before startup, a fixed initialization period and normal operation. Each channel has its own enable bit and moves independently of the others. All delays are counted in sample periods, using a one-cycle sample strobe that runs in the system clock domain. Each enable bit first passes through a two-stage synchronizer.

The block gates each channel's sample word. The output carries live data only when the channel is in normal operation and its optional post-startup mute has run out. At every other time the output is all zeros. The output register loads only on sample strobes, so a gating change never cuts a word in half.

Each channel also drives an analog power control and an active-low analog reset. The reset is released when initialization starts. The mute window covers the click that this release can cause.

Top module: `adc_pwr_seq`

## Requirements
- R1: While rst_ni is low and after it rises, every channel reports state code 0, analog power 0, analog reset 0 and an all-zero sample word.
- R2: Each channel's sequence depends only on its own enable bit. Changing one channel's enable leaves the state and output of every other channel unchanged.
- R3: Once a raised enable has passed the synchronizer, the channel enters WAIT_INIT (code 1) before the next strobe. It enters INIT (code 2) on the third strobe, which is the first strobe plus UP_DLY=2 more.
- R4: INIT lasts INIT_LEN=518 strobes. On the 518th strobe counted in INIT, the channel enters NORMAL (code 3).
- R5: Clearing the enable in NORMAL moves the channel to WAIT_DOWN (code 4). It enters POWERED_DOWN (code 0) on the fifth strobe, which is the first strobe plus DOWN_DLY=4 more.
- R6: On each strobe a channel's output register loads the input word if the channel is in NORMAL with its mute expired, and loads zero otherwise.
- R7: After the move from INIT to NORMAL, the first MUTE_LEN=8 strobes load zero. The strobe after them loads the input word.
- R8: Raising the enable again during WAIT_DOWN returns the channel to NORMAL without a new INIT and without a new mute. Clearing the enable during WAIT_INIT returns the channel to POWERED_DOWN.
- R9: Clearing the enable during INIT returns the channel to POWERED_DOWN before the next strobe.
- R10: Analog power is 1 in every state except POWERED_DOWN. The active-low analog reset is 1 only in INIT, NORMAL and WAIT_DOWN.
- R11: A channel's output word changes only at a clock edge where the strobe is high.
- R12: The state code of channel c sits at bits 3c+2 down to 3c of state_o. It only ever takes the values 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stb_i | input | 1 | One-cycle sample-rate strobe |
| en_i | input | NUM_CH | Per-channel enable (asynchronous) |
| din_i | input | NUM_CH*DATA_W | Per-channel sample words, channel c at bits c*DATA_W upward |
| dout_o | output | NUM_CH*DATA_W | Gated sample words |
| state_o | output | NUM_CH*3 | Per-channel state codes |
| apwr_o | output | NUM_CH | Analog power control per channel |
| arst_no | output | NUM_CH | Active-low analog reset per channel |

## Verification
The bench changes an enable at the falling edge just after a strobe. The synchronizer takes two edges and the sequencer reacts on the third, so the change takes effect before the next strobe, which arrives four cycles after the previous one. State codes, power, reset and gated words are due on the first edge where the strobe is high. The reference model computes an expected entry just before that edge. The monitor compares the entry at the following falling edge. On the falling edges between strobes, the bench checks that every output word still holds the value from the last strobe.

// File: rtl/adc_pwr_seq_pkg.sv
package adc_pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_WAIT_UP = 3'd1,
    ST_INIT    = 3'd2,
    ST_RUN     = 3'd3,
    ST_WAIT_DN = 3'd4
  } ch_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/adc_en_sync.sv
module adc_en_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/adc_ch_seq.sv
module adc_ch_seq
  import adc_pwr_seq_pkg::*;
#(
  parameter int unsigned UP_DLY   = 2,
  parameter int unsigned DOWN_DLY = 4,
  parameter int unsigned INIT_LEN = 518,
  parameter int unsigned MUTE_LEN = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      stb_i,
  input  logic      en_i,
  output ch_state_e state_o,
  output logic      pass_o,
  output logic      apwr_o,
  output logic      arst_no
);
  localparam int unsigned CNT_MAX = max3(UP_DLY, DOWN_DLY, INIT_LEN - 1);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 2);
  localparam int unsigned MUTE_W  = $clog2(MUTE_LEN + 2);

  ch_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [MUTE_W-1:0] mute_q, mute_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    mute_d  = mute_q;
    unique case (state_q)
      ST_OFF: if (en_i) begin
        state_d = ST_WAIT_UP;
        cnt_d   = '0;
      end
      ST_WAIT_UP: begin
        if (!en_i) state_d = ST_OFF;
        else if (stb_i) begin
          if (cnt_q == CNT_W'(UP_DLY)) begin
            state_d = ST_INIT;
            cnt_d   = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
      end
      ST_INIT: begin
        if (!en_i) state_d = ST_OFF;  // abort: analog never reached normal
        else if (stb_i) begin
          if (cnt_q == CNT_W'(INIT_LEN - 1)) begin
            state_d = ST_RUN;
            cnt_d   = '0;
            mute_d  = MUTE_W'(MUTE_LEN);
          end else cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RUN: begin
        if (!en_i) begin
          state_d = ST_WAIT_DN;
          cnt_d   = '0;
        end else if (stb_i && mute_q != '0) mute_d = mute_q - 1'b1;
      end
      ST_WAIT_DN: begin
        if (en_i) state_d = ST_RUN;  // cancel: no re-init, mute kept
        else if (stb_i) begin
          if (cnt_q == CNT_W'(DOWN_DLY)) begin
            state_d = ST_OFF;
            cnt_d   = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      mute_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mute_q  <= mute_d;
    end
  end

  assign state_o = state_q;
  assign pass_o  = (state_q == ST_RUN) && (mute_q == '0);
  assign apwr_o  = (state_q != ST_OFF);
  assign arst_no = (state_q == ST_INIT) || (state_q == ST_RUN) || (state_q == ST_WAIT_DN);

  assert_init_on_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_UP && !stb_i) |=> state_q != ST_INIT);
  assert_no_skip_from_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF) |=> (state_q == ST_OFF || state_q == ST_WAIT_UP));
  assert_down_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_DN && !stb_i && !en_i) |=> state_q == ST_WAIT_DN);
  assert_init_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INIT && !en_i) |=> state_q == ST_OFF);
  assert_run_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INIT && !stb_i && en_i) |=> state_q == ST_INIT);
  assert_legal_code_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q inside {ST_OFF, ST_WAIT_UP, ST_INIT, ST_RUN, ST_WAIT_DN});
  assert_mute_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN && state_q != ST_INIT) |=> $stable(mute_q));
endmodule

// File: rtl/adc_out_gate.sv
module adc_out_gate #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              pass_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o
);
  logic [DATA_W-1:0] dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dout_q <= '0;
    else if (stb_i) dout_q <= pass_i ? din_i : '0;
  end

  assign dout_o = dout_q;

  assert_word_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(dout_q));
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_seq_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned SYNC_STG  = 2,
  parameter int unsigned UP_DLY    = 2,
  parameter int unsigned DOWN_DLY  = 4,
  parameter int unsigned INIT_LEN  = 518,
  parameter int unsigned MUTE_LEN  = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       stb_i,
  input  logic [NUM_CH-1:0]          en_i,
  input  logic [NUM_CH*DATA_W-1:0]   din_i,
  output logic [NUM_CH*DATA_W-1:0]   dout_o,
  output logic [NUM_CH*3-1:0]        state_o,
  output logic [NUM_CH-1:0]          apwr_o,
  output logic [NUM_CH-1:0]          arst_no
);
  logic [NUM_CH-1:0] en_s;

  adc_en_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STG)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (en_i),
    .q_o   (en_s)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ch_state_e st;
    logic      pass;

    adc_ch_seq #(
      .UP_DLY  (UP_DLY),
      .DOWN_DLY(DOWN_DLY),
      .INIT_LEN(INIT_LEN),
      .MUTE_LEN(MUTE_LEN)
    ) i_seq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stb_i  (stb_i),
      .en_i   (en_s[c]),
      .state_o(st),
      .pass_o (pass),
      .apwr_o (apwr_o[c]),
      .arst_no(arst_no[c])
    );

    adc_out_gate #(.DATA_W(DATA_W)) i_gate (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .stb_i (stb_i),
      .pass_i(pass),
      .din_i (din_i[c*DATA_W +: DATA_W]),
      .dout_o(dout_o[c*DATA_W +: DATA_W])
    );

    assign state_o[c*3 +: 3] = st;

    assert_zero_unless_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stb_i && state_o[c*3 +: 3] != 3'd3) |=> dout_o[c*DATA_W +: DATA_W] == '0);
    assert_reset_needs_power_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !apwr_o[c] |-> !arst_no[c]);
  end
endmodule

// File: tb/test_adc_pwr_seq.sv
module test_adc_pwr_seq;
  localparam int NCH = 4;
  localparam int DW  = 24;
  localparam int UPD = 2;
  localparam int DND = 4;
  localparam int INL = 518;
  localparam int MUL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0;
  logic [NCH-1:0] en = '0;
  logic [NCH*DW-1:0] din = '0;
  logic [NCH*DW-1:0] dout;
  logic [NCH*3-1:0] st;
  logic [NCH-1:0] apwr, arstn;

  always #2 clk = ~clk;

  adc_pwr_seq i_adc_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .stb_i(stb), .en_i(en), .din_i(din),
    .dout_o(dout), .state_o(st), .apwr_o(apwr), .arst_no(arstn)
  );

  typedef struct {
    logic [NCH*DW-1:0] dout;
    logic [NCH*3-1:0]  st;
    logic [NCH-1:0]    pwr;
    logic [NCH-1:0]    rstn;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int m_st[NCH], m_cnt[NCH], m_mute[NCH];
  int tick_no = 0;
  logic [NCH*DW-1:0] last_dout = '0;

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: one sample period, strobe on its last edge
  task automatic tick();
    exp_t e;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 hold", dout, last_dout);
    end
    tick_no++;
    for (int c = 0; c < NCH; c++) din[c*DW +: DW] = {8'(c + 1), 16'(tick_no)};
    for (int c = 0; c < NCH; c++) begin
      case (m_st[c])
        0: if (en[c]) begin m_st[c] = 1; m_cnt[c] = 0; end
        1: if (!en[c]) m_st[c] = 0;
        2: if (!en[c]) m_st[c] = 0;
        3: if (!en[c]) begin m_st[c] = 4; m_cnt[c] = 0; end
        4: if (en[c]) m_st[c] = 3;
        default: ;
      endcase
      e.dout[c*DW +: DW] = (m_st[c] == 3 && m_mute[c] == 0) ? din[c*DW +: DW] : '0;
      case (m_st[c])
        1: if (m_cnt[c] == UPD) begin m_st[c] = 2; m_cnt[c] = 0; end else m_cnt[c]++;
        2: if (m_cnt[c] == INL - 1) begin m_st[c] = 3; m_cnt[c] = 0; m_mute[c] = MUL; end
           else m_cnt[c]++;
        3: if (m_mute[c] > 0) m_mute[c]--;
        4: if (m_cnt[c] == DND) begin m_st[c] = 0; m_cnt[c] = 0; end else m_cnt[c]++;
        default: ;
      endcase
      e.st[c*3 +: 3] = 3'(m_st[c]);
      e.pwr[c]  = (m_st[c] != 0);
      e.rstn[c] = (m_st[c] >= 2);
    end
    q.push_back(e);
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      if (stb) begin
        @(negedge clk);
        if (q.size() == 0) chk("R6 queue", 0, 1);
        else begin
          e = q.pop_front();
          chk("R6 dout", dout, e.dout);
          chk("R12 state", st, e.st);
          chk("R10 power", apwr, e.pwr);
          chk("R10 reset", arstn, e.rstn);
        end
        last_dout = dout;
      end
    end
  end

  function automatic int stc(int c);
    return int'(st[c*3 +: 3]);
  endfunction

  initial begin
    for (int c = 0; c < NCH; c++) begin m_st[c] = 0; m_cnt[c] = 0; m_mute[c] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 state in reset", st, 0);
    chk("R1 dout in reset", dout, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state", st, 0);
    chk("R1 power", apwr, 0);
    chk("R1 areset", arstn, 0);
    chk("R1 dout", dout, 0);
    ticks(2);

    en = 4'b0011;
    tick();
    chk("R3 wait_init ch0", stc(0), 1);
    tick();
    chk("R3 still waiting ch0", stc(0), 1);
    tick();
    chk("R3 init ch0", stc(0), 2);
    chk("R10 reset released ch0", arstn[0], 1);
    chk("R2 ch2 untouched", stc(2), 0);
    ticks(INL - 1);
    chk("R4 init not done ch0", stc(0), 2);
    tick();
    chk("R4 normal ch0", stc(0), 3);
    for (int i = 0; i < MUL; i++) begin
      tick();
      chk("R7 muted ch0", dout[0 +: DW], 0);
    end
    tick();
    chk("R7 released ch0", dout[0 +: DW], din[0 +: DW]);
    ticks(3);
    chk("R6 live ch1", dout[DW +: DW], din[DW +: DW]);

    en = 4'b0001;
    tick();
    chk("R5 wait_down ch1", stc(1), 4);
    chk("R6 zero in wait_down", dout[DW +: DW], 0);
    ticks(3);
    chk("R5 still wait_down ch1", stc(1), 4);
    tick();
    chk("R5 off ch1", stc(1), 0);
    chk("R10 power off ch1", apwr[1], 0);
    chk("R2 ch0 kept", dout[0 +: DW], din[0 +: DW]);

    en = 4'b0000;
    ticks(2);
    chk("R8 ch0 wait_down", stc(0), 4);
    en = 4'b0001;
    tick();
    chk("R8 cancel to normal", stc(0), 3);
    chk("R8 no re-mute", dout[0 +: DW], din[0 +: DW]);

    en = 4'b0101;
    tick();
    chk("R8 ch2 wait_init", stc(2), 1);
    en = 4'b0001;
    tick();
    chk("R8 ch2 cancel off", stc(2), 0);

    en = 4'b1001;
    ticks(3);
    chk("R9 ch3 in init", stc(3), 2);
    ticks(10);
    en = 4'b0001;
    tick();
    chk("R9 ch3 aborted", stc(3), 0);
    chk("R2 ch0 running", stc(0), 3);
    ticks(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule